// File: doc/BRIEF.md
# Pipelined Address Bus Cycle Sequencer

This block is the bus-master sequencer of a local bus. The core offers one request at a time: a valid flag, an address and a lock flag. The sequencer takes the request with a one-clock accept pulse. It then runs the bus cycle by driving the address and an active-low address strobe. It inserts wait states until the active-low ready input is sampled low. An active-low early next-address input lets the sequencer issue the following address while the current cycle is still waiting for ready. This overlap shortens a pipelined cycle to two clocks.

A second bus master asks for the bus with `hold`. The sequencer answers with `hlda`, but only at a cycle boundary. It never grants the bus between cycles of a locked sequence. Internally the sequencer moves through seven states: idle, address clock, wait, pipelined-wait-without-request, pipelined-issue, pipelined address clock and hold acknowledge. The data path is not part of this block.

Top module: `pipe_bus_seq`

## Requirements
- R1: After reset, `ads_n` is 1, `hlda` is 0, `bus_addr` is all zeros and no request is accepted until one is offered.
- R2: In idle, with `hold` low, a request with `req_valid` high is accepted (`req_accept` high in that same clock). On the next clock `ads_n` is 0 for exactly one clock and `bus_addr` carries the accepted address.
- R3: After the address clock, each clock with `ready_n` high is a wait state. In a wait state `ads_n` stays 1, `bus_addr` is unchanged and no request is accepted unless R5 or R6 applies.
- R4: When `ready_n` is sampled low in a cycle whose next address has not been issued, the next clock is chosen in this order. If `hold` is high and the cycle was not locked, the next clock is hold acknowledge. Otherwise, if a request is valid, it is accepted and the next clock is an address clock. Otherwise the sequencer goes idle.
- R5: `na_n` is sampled in the pipelined address clock and in wait states where it has not yet been seen. If `na_n` is 0 there, `ready_n` is high and a request is valid, that request is accepted. On the next clock `ads_n` is 0 for one clock with the new address, while the current cycle stays open. No further request is accepted until that cycle ends.
- R6: If `na_n` is seen low with no request valid, no strobe is driven. A request that arrives later in the same cycle is accepted whatever `na_n` is then. The seen state clears when a new cycle starts.
- R7: When a cycle whose next address has already been issued ends with `ready_n` low, the next clock is a pipelined address clock. In that clock `ads_n` stays 1 and `hold` is not granted. The shortest pipelined cycle is one pipelined address clock plus one issue clock.
- R8: In idle, `hold` high takes priority over a valid request. `hlda` rises on the very next clock edge. No request is accepted while `hold` is high in idle or in hold acknowledge.
- R9: Hold acknowledge ends when `hold` is sampled low. If a request is valid, it is accepted in that clock and the next clock is an address clock with `hlda` low. Otherwise the next clock is idle.
- R10: A `hold` request that arrives during a cycle is granted only after `ready_n` is sampled low. `hlda` stays 0 through all of that cycle's wait states.
- R11: At the end of a cycle accepted with `req_lock` high, `hold` is ignored. A valid request is accepted instead. A later unlocked cycle yields to `hold` at its end.
- R12: `ready_n` is not sampled in address clocks or pipelined address clocks. A low value there neither ends the cycle nor skips the wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request pending |
| req_addr | input | ADDR_W | Address of the pending request |
| req_lock | input | 1 | Request belongs to a locked sequence |
| req_accept | output | 1 | Request taken this clock |
| bus_addr | output | ADDR_W | Bus address, held between cycles |
| ads_n | output | 1 | Active-low address strobe |
| hlda | output | 1 | Hold acknowledge |
| ready_n | input | 1 | Active-low cycle end |
| na_n | input | 1 | Active-low early next-address request |
| hold | input | 1 | Bus request from another master |

## Verification
The bench drives `ready_n` low during address clocks. A sequencer that sampled it there would end the cycle early, and an idle-only accept would show up in the following wait clock.

It drops `na_n` with no request pending, then raises it before a request arrives. A design that forgot that `na_n` had been seen would refuse the request. A design that never cleared that memory would accept a request in the next cycle's first wait clock.

It raises `hold` in the issue clock and in the wait clock before it, and at the end of a locked cycle. A sequencer that granted the bus there would drop an issued address or break the locked sequence; a visible `hlda` exposes either fault. The back-to-back T1P/T2P case catches a design that needs an extra clock per pipelined cycle.

// File: rtl/pipe_bus_seq.sv
`timescale 1ns/1ps
module pipe_bus_seq #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_lock,
  output logic              req_accept,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              ads_n,
  output logic              hlda,
  input  logic              ready_n,
  input  logic              na_n,
  input  logic              hold
);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_WAIT, S_PWAIT, S_PISSUE, S_PADDR, S_HOLD
  } state_t;

  state_t            st, st_nx, end_st;
  logic              lock_q, ads_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rdy, na, take_hold, end_acc;

  assign rdy       = !ready_n;
  assign na        = !na_n;
  assign take_hold = hold && !lock_q;
  assign end_acc   = !take_hold && req_valid;
  assign end_st    = take_hold ? S_HOLD : (req_valid ? S_ADDR : S_IDLE);

  always_comb begin
    st_nx      = st;
    req_accept = 1'b0;
    unique case (st)
      S_IDLE: begin
        if (hold) st_nx = S_HOLD;
        else if (req_valid) begin
          st_nx      = S_ADDR;
          req_accept = 1'b1;
        end
      end
      S_ADDR: st_nx = S_WAIT;
      S_PADDR, S_WAIT: begin
        if (st == S_WAIT && rdy) begin
          st_nx      = end_st;
          req_accept = end_acc;
        end else if (na) begin
          if (req_valid) begin
            st_nx      = S_PISSUE;
            req_accept = 1'b1;
          end else st_nx = S_PWAIT;
        end else st_nx = S_WAIT;
      end
      S_PWAIT: begin
        if (rdy) begin
          st_nx      = end_st;
          req_accept = end_acc;
        end else if (req_valid) begin
          st_nx      = S_PISSUE;
          req_accept = 1'b1;
        end
      end
      S_PISSUE: if (rdy) st_nx = S_PADDR;
      S_HOLD: begin
        if (!hold) begin
          if (req_valid) begin
            st_nx      = S_ADDR;
            req_accept = 1'b1;
          end else st_nx = S_IDLE;
        end
      end
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ads_q  <= 1'b0;
      lock_q <= 1'b0;
      addr_q <= '0;
    end else begin
      st    <= st_nx;
      ads_q <= req_accept;
      if (req_accept) begin
        addr_q <= req_addr;
        lock_q <= req_lock;
      end
    end
  end

  assign ads_n    = !ads_q;
  assign hlda     = (st == S_HOLD);
  assign bus_addr = addr_q;

endmodule

// File: rtl/pipe_bus_seq_chk.sv
`timescale 1ns/1ps
module pipe_bus_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_accept,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              ads_n,
  input logic              hlda,
  input logic              hold
);

  assert_accept_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |-> req_valid);

  assert_accept_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> !ads_n);

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ads_n |=> ads_n);

  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_accept |=> $stable(bus_addr));

  assert_hlda_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> ads_n);

  assert_hlda_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda) |-> $past(hold));

  assert_no_accept_in_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hlda && hold) |-> !req_accept);

  assert_hlda_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hlda && !hold) |=> !hlda);

endmodule

bind pipe_bus_seq pipe_bus_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/pipe_bus_seq_tb.sv
`timescale 1ns/1ps
module pipe_bus_seq_tb;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_lock = 1'b0;
  logic          req_accept;
  logic [AW-1:0] bus_addr;
  logic          ads_n, hlda;
  logic          ready_n = 1'b1;
  logic          na_n = 1'b1;
  logic          hold = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pipe_bus_seq #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_lock(req_lock), .req_accept(req_accept), .bus_addr(bus_addr),
    .ads_n(ads_n), .hlda(hlda), .ready_n(ready_n), .na_n(na_n), .hold(hold)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic offer(input logic v, input logic [AW-1:0] a, input logic l);
    req_valid = v;
    req_addr  = a;
    req_lock  = l;
    #0.5;
  endtask

  task automatic probe_idle(input string tag);
    offer(1'b1, 32'hDEAD_0000, 1'b0);
    chk(tag, req_accept, 1);
    offer(1'b0, '0, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 ads_n", ads_n, 1);
    chk("R1 hlda", hlda, 0);
    chk("R1 bus_addr", bus_addr, 0);
    chk("R1 accept", req_accept, 0);
    probe_idle("R1 idle accepts");
  endtask

  task automatic t_basic();
    offer(1'b1, 32'h0000_1000, 1'b0);
    chk("R2 accept in idle", req_accept, 1);
    cyc();
    chk("R2 strobe", ads_n, 0);
    chk("R2 address", bus_addr, 32'h0000_1000);
    ready_n = 1'b0;
    offer(1'b0, '0, 1'b0);
    cyc();
    chk("R2 strobe one clock", ads_n, 1);
    ready_n = 1'b1;
    offer(1'b1, 32'h0000_2000, 1'b0);
    chk("R12 ready ignored in address clock", req_accept, 0);
    cyc();
    chk("R3 wait no strobe", ads_n, 1);
    chk("R3 wait addr held", bus_addr, 32'h0000_1000);
    chk("R3 wait no accept", req_accept, 0);
    cyc();
    chk("R3 second wait no accept", req_accept, 0);
    ready_n = 1'b0;
    #0.5;
    chk("R4 back-to-back accept", req_accept, 1);
    cyc();
    chk("R4 next strobe", ads_n, 0);
    chk("R4 next address", bus_addr, 32'h0000_2000);
    offer(1'b0, '0, 1'b0);
    ready_n = 1'b1;
    cyc();
    ready_n = 1'b0;
    cyc();
    ready_n = 1'b1;
    chk("R4 idle addr held", bus_addr, 32'h0000_2000);
    probe_idle("R4 back to idle");
  endtask

  task automatic t_pipe();
    offer(1'b1, 32'h0000_3000, 1'b0);
    cyc();
    chk("R2 strobe A3", ads_n, 0);
    na_n = 1'b0;
    offer(1'b1, 32'h0000_4000, 1'b0);
    chk("R5 na not sampled in address clock", req_accept, 0);
    cyc();
    chk("R5 early accept", req_accept, 1);
    cyc();
    chk("R5 issue strobe", ads_n, 0);
    chk("R5 issue address", bus_addr, 32'h0000_4000);
    hold = 1'b1;
    offer(1'b1, 32'h0000_5000, 1'b0);
    chk("R5 no accept in issue", req_accept, 0);
    cyc();
    chk("R5 strobe one clock", ads_n, 1);
    chk("R7 no hold in issue wait", hlda, 0);
    ready_n = 1'b0;
    #0.5;
    chk("R7 no accept at issue end", req_accept, 0);
    cyc();
    chk("R7 pipelined address clock no hold", hlda, 0);
    chk("R7 pipelined address clock no strobe", ads_n, 1);
    hold = 1'b0;
    #0.5;
    chk("R7 accept in pipelined address clock", req_accept, 1);
    cyc();
    chk("R7 shortest pipelined strobe", ads_n, 0);
    chk("R7 shortest pipelined address", bus_addr, 32'h0000_5000);
    offer(1'b0, '0, 1'b0);
    cyc();
    na_n = 1'b1;
    ready_n = 1'b1;
    cyc();
    ready_n = 1'b0;
    cyc();
    ready_n = 1'b1;
    probe_idle("R4 idle after pipelined run");
  endtask

  task automatic t_na_idle();
    offer(1'b1, 32'h0000_6000, 1'b0);
    cyc();
    offer(1'b0, '0, 1'b0);
    na_n = 1'b0;
    cyc();
    cyc();
    chk("R6 no strobe without request", ads_n, 1);
    na_n = 1'b1;
    offer(1'b1, 32'h0000_7000, 1'b0);
    chk("R6 late request accepted", req_accept, 1);
    cyc();
    chk("R6 late strobe", ads_n, 0);
    chk("R6 late address", bus_addr, 32'h0000_7000);
    offer(1'b0, '0, 1'b0);
    ready_n = 1'b0;
    cyc();
    ready_n = 1'b1;
    cyc();
    offer(1'b1, 32'h0000_7100, 1'b0);
    chk("R6 seen state cleared", req_accept, 0);
    offer(1'b0, '0, 1'b0);
    ready_n = 1'b0;
    cyc();
    ready_n = 1'b1;
  endtask

  task automatic t_hold_idle();
    hold = 1'b1;
    offer(1'b1, 32'h0000_8000, 1'b0);
    chk("R8 hold beats request", req_accept, 0);
    cyc();
    chk("R8 hlda next edge", hlda, 1);
    chk("R8 no accept in hold", req_accept, 0);
    cyc();
    chk("R8 hlda kept", hlda, 1);
    hold = 1'b0;
    #0.5;
    chk("R9 accept on release", req_accept, 1);
    cyc();
    chk("R9 hlda dropped", hlda, 0);
    chk("R9 strobe after hold", ads_n, 0);
    chk("R9 address after hold", bus_addr, 32'h0000_8000);
    offer(1'b0, '0, 1'b0);
    cyc();
    ready_n = 1'b0;
    cyc();
    ready_n = 1'b1;
    hold = 1'b1;
    cyc();
    chk("R8 hlda again", hlda, 1);
    hold = 1'b0;
    cyc();
    chk("R9 release to idle", hlda, 0);
    probe_idle("R9 idle after release");
  endtask

  task automatic t_hold_cycle();
    offer(1'b1, 32'h0000_9000, 1'b0);
    cyc();
    offer(1'b0, '0, 1'b0);
    hold = 1'b1;
    cyc();
    chk("R10 no hlda in wait", hlda, 0);
    cyc();
    chk("R10 no hlda in second wait", hlda, 0);
    ready_n = 1'b0;
    offer(1'b1, 32'h0000_9100, 1'b0);
    chk("R4 hold wins at end", req_accept, 0);
    cyc();
    chk("R10 hlda after ready", hlda, 1);
    ready_n = 1'b1;
    offer(1'b0, '0, 1'b0);
    hold = 1'b0;
    cyc();
    chk("R9 hlda clear", hlda, 0);
  endtask

  task automatic t_lock();
    offer(1'b1, 32'h0000_A000, 1'b1);
    cyc();
    offer(1'b0, '0, 1'b0);
    cyc();
    hold = 1'b1;
    ready_n = 1'b0;
    offer(1'b1, 32'h0000_B000, 1'b0);
    chk("R11 hold ignored after locked cycle", req_accept, 1);
    cyc();
    chk("R11 no hlda", hlda, 0);
    chk("R11 next strobe", ads_n, 0);
    chk("R11 next address", bus_addr, 32'h0000_B000);
    offer(1'b0, '0, 1'b0);
    ready_n = 1'b1;
    cyc();
    ready_n = 1'b0;
    cyc();
    chk("R11 unlocked cycle yields", hlda, 1);
    ready_n = 1'b1;
    hold = 1'b0;
    cyc();
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    rst_n = 1'b1;
    #0.5;
    t_reset();
    t_basic();
    t_pipe();
    t_na_idle();
    t_hold_idle();
    t_hold_cycle();
    t_lock();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule